// File: doc/BRIEF.md
# Registered Barrel Shifter with Carry and Extend Flags

This block shifts a data word left logically, right logically or right arithmetically by an amount taken from a full-width register operand. Alongside the shifted word it returns a carry bit, which holds the last bit pushed out of the word, and an extend bit that always matches that carry. It is intended for the shift stage of a processor datapath. The flag-setting rules for oversized shift amounts are fixed in hardware.

Only the low bits of the count operand are used, so the count wraps modulo twice the data width. Counts equal to or larger than the data width give defined results. A count of zero leaves the word unchanged and passes an incoming carry straight through, so a shift by zero keeps the flag state it found. The three operations share one shift network. The inputs are sampled on every rising clock edge, and the outputs are registered, which gives one cycle of latency.

Top module: `shf_core`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o`, `carry_o` and `ext_o` become 0 after that edge.
- R2: Only count bits [5:0] are used when W=32. The effective count is `cnt_i` modulo 64, and bits above bit 5 have no effect on any output.
- R3: When the effective count is 0, `res_o` equals `val_i` and `carry_o` equals `cin_i`, for every operation code.
- R4: When `op_i`=0 (logical left) and the effective count n is 1..31, `res_o` = `val_i` << n and `carry_o` = `val_i`[32−n].
- R5: When `op_i`=0 and n=32, `res_o`=0 and `carry_o`=`val_i`[0]. When `op_i`=0 and n is 33..63, `res_o`=0 and `carry_o`=0.
- R6: When `op_i`=1 (logical right) and n is 1..31, `res_o` = `val_i` >> n with zero fill and `carry_o` = `val_i`[n−1].
- R7: When `op_i`=1 and n=32, `res_o`=0 and `carry_o`=`val_i`[31]. When `op_i`=1 and n is 33..63, `res_o`=0 and `carry_o`=0.
- R8: When `op_i`=2 (arithmetic right) and n is 1..31, `res_o` is `val_i` shifted right by n with the sign bit filling the vacated positions, and `carry_o` = `val_i`[n−1].
- R9: When `op_i`=2 and n is 32..63, every bit of `res_o` equals `val_i`[31] and `carry_o`=`val_i`[31].
- R10: `ext_o` always equals `carry_o`.
- R11: The outputs reflect the inputs that were sampled at the previous rising edge, which is exactly one cycle of latency.
- R12: Operation code 3 behaves exactly like code 1 (logical right).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| val_i | input | W (32) | Word to shift |
| cnt_i | input | 32 | Shift count; only its low log2(W)+1 bits are used |
| op_i | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 same as 1 |
| cin_i | input | 1 | Previous carry, returned when the count is zero |
| res_o | output | W (32) | Registered shifted word |
| carry_o | output | 1 | Registered carry-out |
| ext_o | output | 1 | Registered extend flag, equal to carry_o |

## Verification
The checker assumes that the inputs are stable and known at every rising edge once reset has been released. Its properties compare each output against the inputs sampled one edge earlier, and they stay disarmed until one full cycle after reset has been released. The bench changes its inputs only on falling edges and holds them across the following rising edge. The random counts are drawn from the whole 32-bit range, so the upper count bits are exercised under the same rule. The directed cases pin counts to 0, 1, 31, 32, 33, 63, 64 and to values with high garbage bits.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ALT = 2'd3
  } shf_op_e;

  typedef enum logic [1:0] {
    CNT_ZERO = 2'd0,
    CNT_PART = 2'd1,
    CNT_FULL = 2'd2,
    CNT_OVER = 2'd3
  } cnt_cls_e;
endpackage

// File: rtl/shf_cnt_decode.sv
module shf_cnt_decode
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 32,
  localparam int SB = $clog2(W)
) (
  input  logic [CW-1:0] cnt,
  output logic [SB-1:0] amt,
  output cnt_cls_e      cls
);
  logic [SB:0] eff;

  always_comb begin
    eff = cnt[SB:0];
    amt = eff[SB-1:0];
    if (eff == '0)
      cls = CNT_ZERO;
    else if (!eff[SB])
      cls = CNT_PART;
    else if (eff[SB-1:0] == '0)
      cls = CNT_FULL;
    else
      cls = CNT_OVER;
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int W = 32,
  localparam int SB = $clog2(W)
) (
  input  logic [W:0]    din,
  input  logic          fill,
  input  logic [SB-1:0] amt,
  output logic [W:0]    dout
);
  logic [W:0] stg [0:SB];

  assign stg[0] = din;

  for (genvar s = 0; s < SB; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W:D]} : stg[s];
  end

  assign dout = stg[SB];
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  val_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    op_i,
  input  logic          cin_i,
  output logic [W-1:0]  res_o,
  output logic          carry_o,
  output logic          ext_o
);
  localparam int SB = $clog2(W);

  shf_op_e      op;
  cnt_cls_e     cls;
  logic [SB-1:0] amt;
  logic         go_left;
  logic [W-1:0] val_rev;
  logic [W-1:0] net_in;
  logic [W:0]   net_out;
  logic [W-1:0] part_raw;
  logic [W-1:0] part_rev;
  logic         fill;
  logic         sign;
  logic [W-1:0] res_n;
  logic         carry_n;

  assign op      = shf_op_e'(op_i);
  assign go_left = (op == SH_LSL);
  assign sign    = val_i[W-1];
  assign fill    = (op == SH_ASR) & sign;

  shf_cnt_decode #(.W(W), .CW(CW)) u_dec (
    .cnt (cnt_i),
    .amt (amt),
    .cls (cls)
  );

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign val_rev[i]  = val_i[W-1-i];
    assign part_rev[i] = part_raw[W-1-i];
  end

  assign net_in = go_left ? val_rev : val_i;

  shf_barrel #(.W(W)) u_net (
    .din  ({net_in, 1'b0}),
    .fill (fill),
    .amt  (amt),
    .dout (net_out)
  );

  assign part_raw = net_out[W:1];

  always_comb begin
    res_n   = val_i;
    carry_n = cin_i;
    unique case (cls)
      CNT_ZERO: begin
        res_n   = val_i;
        carry_n = cin_i;
      end
      CNT_PART: begin
        res_n   = go_left ? part_rev : part_raw;
        carry_n = net_out[0];
      end
      CNT_FULL: begin
        res_n   = (op == SH_ASR) ? {W{sign}} : '0;
        carry_n = go_left ? val_i[0] : sign;
      end
      CNT_OVER: begin
        res_n   = (op == SH_ASR) ? {W{sign}} : '0;
        carry_n = (op == SH_ASR) ? sign : 1'b0;
      end
      default: begin
        res_n   = val_i;
        carry_n = cin_i;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
      ext_o   <= 1'b0;
    end else begin
      res_o   <= res_n;
      carry_o <= carry_n;
      ext_o   <= carry_n;
    end
  end
endmodule

// File: rtl/shf_core_chk.sv
module shf_core_chk #(
  parameter int W  = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  val_i,
  input logic [CW-1:0] cnt_i,
  input logic [1:0]    op_i,
  input logic          cin_i,
  input logic [W-1:0]  res_o,
  input logic          carry_o,
  input logic          ext_o
);
  localparam int SB = $clog2(W);
  localparam logic [SB:0] FULLC = (SB+1)'(W);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !carry_o && !ext_o));

  // R10
  ext_match_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ext_o == carry_o);

  // R3
  zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt_i[SB:0] == '0) |=> (res_o == $past(val_i) && carry_o == $past(cin_i)));

  // R5
  left_full_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_i == 2'd0 && cnt_i[SB:0] == FULLC) |=> (res_o == '0 && carry_o == $past(val_i[0])));

  // R9
  asr_big_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_i == 2'd2 && cnt_i[SB]) |=>
      (res_o == {W{$past(val_i[W-1])}} && carry_o == $past(val_i[W-1])));

  // R7
  lsr_over_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && op_i[0] && cnt_i[SB] && cnt_i[SB-1:0] != '0) |=> (res_o == '0 && !carry_o));
endmodule

bind shf_core shf_core_chk #(.W(W), .CW(CW)) u_chk (.*);

// File: tb/sim_shf_core.sv
module sim_shf_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] val_i = '0;
  logic [31:0] cnt_i = '0;
  logic [1:0]  op_i = '0;
  logic        cin_i = 1'b0;
  logic [31:0] res_o;
  logic        carry_o;
  logic        ext_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  shf_core u0 (
    .clk(clk), .rst(rst), .val_i(val_i), .cnt_i(cnt_i),
    .op_i(op_i), .cin_i(cin_i), .res_o(res_o), .carry_o(carry_o), .ext_o(ext_o)
  );

  function automatic logic [32:0] model(input logic [1:0] op, input logic [31:0] v,
                                        input logic [31:0] c, input logic ci);
    int n;
    logic [31:0] r;
    logic cy;
    n = int'(c & 32'd63);
    if (n == 0) begin
      r = v; cy = ci;
    end else if (op == 2'd0) begin
      if (n < 32)       begin r = v << n; cy = v[32-n]; end
      else if (n == 32) begin r = '0; cy = v[0]; end
      else              begin r = '0; cy = 1'b0; end
    end else if (op == 2'd2) begin
      if (n < 32) begin r = 32'($signed(v) >>> n); cy = v[n-1]; end
      else        begin r = {32{v[31]}}; cy = v[31]; end
    end else begin
      if (n < 32)       begin r = v >> n; cy = v[n-1]; end
      else if (n == 32) begin r = '0; cy = v[31]; end
      else              begin r = '0; cy = 1'b0; end
    end
    return {cy, r};
  endfunction

  function automatic string tag(input logic [1:0] op, input logic [31:0] c);
    int n;
    n = int'(c & 32'd63);
    if (c[31:6] != 0) return "R2";
    if (n == 0)       return "R3";
    if (op == 2'd3)   return "R12";
    if (op == 2'd0)   return (n < 32) ? "R4" : "R5";
    if (op == 2'd1)   return (n < 32) ? "R6" : "R7";
    return (n < 32) ? "R8" : "R9";
  endfunction

  task automatic run(input logic [1:0] op, input logic [31:0] v,
                     input logic [31:0] c, input logic ci);
    logic [32:0] exp;
    string t;
    @(negedge clk);
    op_i = op; val_i = v; cnt_i = c; cin_i = ci;
    exp = model(op, v, c, ci);
    t = tag(op, c);
    @(posedge clk); #1;
    // R11: the output follows one edge after the inputs are applied
    checks++;
    if (res_o !== exp[31:0] || carry_o !== exp[32]) begin
      fails++;
      $display("FAIL %s op=%0d v=%h c=%h: got res=%h c=%b exp res=%h c=%b",
               t, op, v, c, res_o, carry_o, exp[31:0], exp[32]);
    end
    // R10
    checks++;
    if (ext_o !== carry_o) begin
      fails++;
      $display("FAIL R10 ext=%b exp=%b", ext_o, carry_o);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got hung exp finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    val_i = 32'hDEADBEEF; cnt_i = 32'd5; cin_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1
    checks++;
    if (res_o !== '0 || carry_o !== 1'b0 || ext_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 got res=%h c=%b e=%b exp 0", res_o, carry_o, ext_o);
    end
    @(negedge clk); rst = 1'b0;

    for (int op = 0; op < 4; op++) begin
      run(2'(op), 32'h8000_0001, 32'd0, 1'b1);
      run(2'(op), 32'h8000_0001, 32'd0, 1'b0);
      run(2'(op), 32'hC3A5_5A3C, 32'd1, 1'b0);
      run(2'(op), 32'h8000_0001, 32'd31, 1'b1);
      run(2'(op), 32'h8000_0001, 32'd32, 1'b0);
      run(2'(op), 32'h7FFF_FFFE, 32'd32, 1'b1);
      run(2'(op), 32'hFFFF_FFFF, 32'd33, 1'b1);
      run(2'(op), 32'h9234_5678, 32'd63, 1'b0);
      run(2'(op), 32'h1234_5678, 32'd64, 1'b1);
      run(2'(op), 32'hA5A5_A5A5, 32'hFFFF_FFE0, 1'b0);
      run(2'(op), 32'hA5A5_A5A5, 32'hFFFF_FF07, 1'b1);
    end
    for (int i = 0; i < 400; i++) begin
      logic [31:0] c;
      c = $urandom();
      if (i % 2 == 0) c = c & 32'd63;
      run(2'($urandom_range(0, 3)), $urandom(), c, 1'($urandom()));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule